// File: doc/BRIEF.md
# Recursive Tessellation Dither Table Generator

This block fills a small on-chip table with a one-dimensional ordered-dither ramp of 2^N entries. It does not wire the address bits in reverse order. It builds the table the way the ramp is defined: a tile covering the whole period is split again and again, and the centre of every tile receives the value at the tile's left edge plus a per-pass increment. Each split halves the tile size and doubles the increment. The finished table holds, at every address, that address with its N low bits in reverse order.

A client pulses `start` while the block is idle and supplies the table order on `n_sel`. The block raises `busy` and steps through the passes, one read and one write of the single-port table for each new entry. It then returns to idle with a one-cycle `done` pulse. While idle, the table is read through a synchronous read port.

Top module: `ditgen_top`

## Requirements
- R1: After reset, `busy` and `done` are both low.
- R2: A `start` pulse while idle makes `busy` high from the next clock edge.
- R3: After a run of order N, entry a (for 0 <= a < 2^N) equals a with its N low bits reversed, so order 3 gives 0,4,2,6,1,5,3,7.
- R4: `busy` stays high for exactly 2^(N+1)-1 cycles: one cycle to seed entry 0 and two cycles for each of the other 2^N-1 entries.
- R5: `done` is high for exactly one cycle, the first cycle in which `busy` is low after a run.
- R6: A `start` pulse while busy is ignored: the run's length and its resulting table are those of the first request.
- R7: Order 0 writes only entry 0 with the value 0, and `busy` lasts one cycle.
- R8: An `n_sel` value above the parameter NMAX is treated as NMAX.
- R9: While `busy` is low, `rd_data` shows the entry at `rd_addr` one cycle after the address is presented. The generator writes the table only while busy.
- R10: `n_sel` is sampled only in the start cycle. Changes during a run have no effect.
- R11: A run of order N writes only addresses below 2^N. Higher entries keep their earlier contents.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request to build the table (taken only while idle) |
| n_sel | input | $clog2(NMAX+1) | Table order N; the table has 2^N entries |
| busy | output | 1 | High while the table is being built |
| done | output | 1 | One-cycle pulse when a build finishes |
| rd_addr | input | NMAX | Table read address |
| rd_data | output | NMAX | Entry at the previous cycle's `rd_addr` |

## Verification
Runs are requested for every order from 0 to NMAX, plus two values above NMAX. The full table is read back after each run, so each order's bit-reversed pattern is compared separately from the others. Run length tells a per-entry two-cycle schedule apart from a schedule that skips or repeats a pass. The above-NMAX requests separate clamping from plain truncation of `n_sel`. A long run followed by a short one shows whether the short run stays inside its own region. A second start and a change of `n_sel` during a run show whether the run's order is latched once.

// File: rtl/ditgen_pkg.sv
package ditgen_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_SEED = 2'd1,
        ST_FETCH = 2'd2,
        ST_PLACE = 2'd3
    } dg_state_e;

endpackage

// File: rtl/ditgen_ram.sv
module ditgen_ram #(
    parameter int AW = 5,
    parameter int DW = 5
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[addr] <= wdata;
        end
        rdata <= mem[addr];
    end

endmodule

// File: rtl/ditgen_seq.sv
module ditgen_seq
    import ditgen_pkg::*;
#(
    parameter int NMAX = 5
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        start,
    input  logic [$clog2(NMAX+1)-1:0]   n_sel,
    output logic                        busy,
    output logic                        done,
    output logic [$clog2(NMAX+1)-1:0]   run_n,
    output logic                        ram_we,
    output logic [NMAX-1:0]             ram_addr,
    output logic [NMAX-1:0]             ram_wdata,
    input  logic [NMAX-1:0]             ram_rdata
);
    localparam int AW = NMAX;
    localparam int PW = AW + 1;
    localparam int NW = $clog2(NMAX + 1);

    typedef struct packed {
        dg_state_e     st;
        logic [NW-1:0] n;
        logic [NW-1:0] pass;
        logic [PW-1:0] tile;
        logic [AW-1:0] delta;
        logic [PW-1:0] base;
        logic          done;
    } seq_t;

    seq_t r_d, r_q;

    logic [NW-1:0] n_clamp;
    logic [PW-1:0] span;
    logic [PW-1:0] next_base;

    always_comb begin
        n_clamp   = (n_sel > NW'(NMAX)) ? NW'(NMAX) : n_sel;
        span      = PW'(1) << r_q.n;
        next_base = r_q.base + r_q.tile;

        r_d       = r_q;
        r_d.done  = 1'b0;
        ram_we    = 1'b0;
        ram_addr  = AW'(r_q.base);
        ram_wdata = ram_rdata + r_q.delta;

        case (r_q.st)
            ST_IDLE: begin
                if (start) begin
                    r_d.n     = n_clamp;
                    r_d.pass  = '0;
                    r_d.tile  = PW'(1) << n_clamp;
                    r_d.delta = AW'(1);
                    r_d.base  = '0;
                    r_d.st    = ST_SEED;
                end
            end
            ST_SEED: begin
                ram_we    = 1'b1;
                ram_addr  = '0;
                ram_wdata = '0;
                if (r_q.n == '0) begin
                    r_d.st   = ST_IDLE;
                    r_d.done = 1'b1;
                end else begin
                    r_d.st = ST_FETCH;
                end
            end
            ST_FETCH: begin
                r_d.st = ST_PLACE;
            end
            ST_PLACE: begin
                ram_we   = 1'b1;
                ram_addr = AW'(r_q.base + (r_q.tile >> 1));
                if (next_base == span) begin
                    if (r_q.pass + NW'(1) == r_q.n) begin
                        r_d.st   = ST_IDLE;
                        r_d.done = 1'b1;
                    end else begin
                        r_d.pass  = r_q.pass + NW'(1);
                        r_d.tile  = r_q.tile >> 1;
                        r_d.delta = r_q.delta << 1;
                        r_d.base  = '0;
                        r_d.st    = ST_FETCH;
                    end
                end else begin
                    r_d.base = next_base;
                    r_d.st   = ST_FETCH;
                end
            end
            default: begin
                r_d.st = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{st: ST_IDLE, n: '0, pass: '0, tile: '0,
                     delta: '0, base: '0, done: 1'b0};
        end else begin
            r_q <= r_d;
        end
    end

    assign busy  = (r_q.st != ST_IDLE);
    assign done  = r_q.done;
    assign run_n = r_q.n;

endmodule

// File: rtl/ditgen_top.sv
module ditgen_top #(
    parameter int NMAX = 5
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       start,
    input  logic [$clog2(NMAX+1)-1:0]  n_sel,
    output logic                       busy,
    output logic                       done,
    input  logic [NMAX-1:0]            rd_addr,
    output logic [NMAX-1:0]            rd_data
);
    localparam int AW = NMAX;
    localparam int NW = $clog2(NMAX + 1);

    logic [NW-1:0] run_n;
    logic          seq_we;
    logic [AW-1:0] seq_addr;
    logic [AW-1:0] seq_wdata;
    logic [AW-1:0] ram_addr;
    logic [AW-1:0] ram_rdata;

    ditgen_seq #(.NMAX(NMAX)) i_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .n_sel     (n_sel),
        .busy      (busy),
        .done      (done),
        .run_n     (run_n),
        .ram_we    (seq_we),
        .ram_addr  (seq_addr),
        .ram_wdata (seq_wdata),
        .ram_rdata (ram_rdata)
    );

    assign ram_addr = busy ? seq_addr : rd_addr;

    ditgen_ram #(.AW(AW), .DW(AW)) i_ram (
        .clk   (clk),
        .we    (seq_we),
        .addr  (ram_addr),
        .wdata (seq_wdata),
        .rdata (ram_rdata)
    );

    assign rd_data = ram_rdata;

endmodule

// File: rtl/ditgen_chk.sv
module ditgen_chk #(
    parameter int NMAX = 5
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       busy,
    input logic                       done,
    input logic [$clog2(NMAX+1)-1:0]  run_n,
    input logic                       seq_we,
    input logic [NMAX-1:0]            seq_addr
);
    localparam int PW = NMAX + 1;
    localparam int CW = NMAX + 2;

    logic [CW-1:0] busy_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            busy_cnt <= '0;
        end else if (busy) begin
            busy_cnt <= busy_cnt + CW'(1);
        end else begin
            busy_cnt <= '0;
        end
    end

    p_done_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_done_at_fall_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);

    p_run_length_r4: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (busy_cnt == ((CW'(2) << run_n) - CW'(1))));

    p_write_when_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
        seq_we |-> busy);

    p_write_in_range_r11: assert property (@(posedge clk) disable iff (!rst_n)
        seq_we |-> ({1'b0, seq_addr} < (PW'(1) << run_n)));

    p_order_held_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(run_n));

endmodule

bind ditgen_top ditgen_chk #(.NMAX(NMAX)) i_ditgen_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .busy     (busy),
    .done     (done),
    .run_n    (run_n),
    .seq_we   (seq_we),
    .seq_addr (seq_addr)
);

// File: tb/test_ditgen_top.sv
module test_ditgen_top;
    localparam int NMAX = 5;
    localparam int NW   = $clog2(NMAX + 1);
    localparam int NV   = 8;

    // stimulus n_sel, effective order, expected busy length
    localparam int VEC_N[NV]   = '{3, 1, 5, 0, 2, 4, 7, 6};
    localparam int VEC_EFF[NV] = '{3, 1, 5, 0, 2, 4, 5, 5};
    localparam int VEC_LEN[NV] = '{15, 3, 63, 1, 7, 31, 63, 63};

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            start = 1'b0;
    logic [NW-1:0]   n_sel = '0;
    logic            busy;
    logic            done;
    logic [NMAX-1:0] rd_addr = '0;
    logic [NMAX-1:0] rd_data;

    int n_chk = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    ditgen_top #(.NMAX(NMAX)) i_ditgen_top (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start),
        .n_sel   (n_sel),
        .busy    (busy),
        .done    (done),
        .rd_addr (rd_addr),
        .rd_data (rd_data)
    );

    function automatic int bitrev(input int a, input int n);
        int r = 0;
        for (int i = 0; i < n; i++) begin
            if (((a >> i) & 1) != 0) r = r | (1 << (n - 1 - i));
        end
        return r;
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // poke: 0 none, 1 extra start pulse with poke_n, 2 change n_sel to poke_n
    task automatic run_gen(input int nsel, input int poke, input int poke_n,
                           output int len, output int first_busy,
                           output int done_end, output int done_next);
        @(negedge clk);
        start = 1'b1;
        n_sel = NW'(nsel);
        @(negedge clk);
        start = 1'b0;
        first_busy = int'(busy);
        len = 0;
        while (busy && len < 1000) begin
            if (len == 3 && poke == 1) begin
                start = 1'b1;
                n_sel = NW'(poke_n);
            end
            if (len == 3 && poke == 2) n_sel = NW'(poke_n);
            if (len == 4) start = 1'b0;
            len++;
            @(negedge clk);
        end
        start = 1'b0;
        done_end = int'(done);
        @(negedge clk);
        done_next = int'(done);
    endtask

    task automatic read_span(input string req, input int lo, input int hi, input int n);
        for (int a = lo; a < hi; a++) begin
            rd_addr = NMAX'(a);
            @(negedge clk);
            chk(req, int'(rd_data), bitrev(a, n));
        end
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual 1 expected 0");
        finish_run();
    end

    initial begin
        int len, fb, de, dn;
        // R1: reset state
        repeat (3) @(negedge clk);
        chk("R1 busy", int'(busy), 0);
        chk("R1 done", int'(done), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk("R1 busy after release", int'(busy), 0);
        chk("R1 done after release", int'(done), 0);

        // vector walk: R2 R3 R4 R5 R7 R8 R9
        for (int v = 0; v < NV; v++) begin
            run_gen(VEC_N[v], 0, 0, len, fb, de, dn);
            chk("R2 busy after start", fb, 1);
            chk(VEC_EFF[v] == 0 ? "R7 length" : "R4 length", len, VEC_LEN[v]);
            chk("R5 done at fall", de, 1);
            chk("R5 done single", dn, 0);
            if (VEC_N[v] > NMAX) read_span("R8 clamped table", 0, 1 << NMAX, NMAX);
            else if (VEC_EFF[v] == 0) read_span("R7 entry 0", 0, 1, 0);
            else read_span("R3 table", 0, 1 << VEC_EFF[v], VEC_EFF[v]);
        end

        // R11: short run keeps the upper region of the last full run
        run_gen(2, 0, 0, len, fb, de, dn);
        chk("R11 length", len, 7);
        read_span("R11 lower region", 0, 4, 2);
        read_span("R11 upper untouched", 4, 1 << NMAX, NMAX);

        // R6: second start during a run is ignored
        run_gen(3, 1, 5, len, fb, de, dn);
        chk("R6 length", len, 15);
        chk("R6 busy after end", int'(busy), 0);
        read_span("R6 table", 0, 8, 3);

        // R10: n_sel change during a run is ignored
        run_gen(4, 2, 1, len, fb, de, dn);
        chk("R10 length", len, 31);
        read_span("R10 table", 0, 16, 4);

        // R9: one-cycle read latency while idle
        rd_addr = NMAX'(1);
        @(negedge clk);
        chk("R9 read a=1", int'(rd_data), 8);
        rd_addr = NMAX'(3);
        #1;
        chk("R9 data held until edge", int'(rd_data), 8);
        @(negedge clk);
        chk("R9 read a=3", int'(rd_data), 12);

        finish_run();
    end

endmodule